// File: doc/BRIEF.md
# Stereo Serial Audio Port with Selectable Sample Justification

This block moves 16-bit stereo samples between a serial audio link and a parallel processing core. The receive half follows a bit clock and a word clock that come from outside, at any ratio of 32 bit periods per frame or more. It pulls one sample per channel out of each frame. A mode input says whether the sample occupies the first 16 bit slots of each channel half or the last 16. The two samples of a frame go to the core together, as a pair, with a single-cycle strobe.

The transmit half runs from the block clock, which is the 384x-sample-rate master clock. It divides that clock into its own bit clock and word clock. The bit clock runs at either 48 or 64 periods per frame. Each channel sample sits at the end of its half-frame, and the leading slots are filled with zeros. The core offers pairs through a valid/ready handshake. A pair that is accepted goes out in the next frame. If no pair is waiting at a frame start, that frame carries silence. The master clock is also passed out unchanged, so that it travels alongside the serial data.

All external receive signals are brought into the block clock domain by a synchronizer. The receive bit clock must therefore stay at each level for at least three block clock cycles.

Top module: `sap_port`

## Requirements
- R1: While reset is held and in the first cycle after it: tx_lrck_o is 1, tx_bclk_o is 0, tx_data_o is 0, tx_ready_o is 1 and rx_valid_o is 0.
- R2: The transmit bit clock has a 50% duty cycle. With tx_fast_i low its period is 8 clocks and each word-clock level lasts 24 bit periods. With tx_fast_i high its period is 6 clocks and each level lasts 32 bit periods.
- R3: tx_lrck_o and tx_data_o change only in the cycle in which tx_bclk_o falls.
- R4: In each half-frame, every slot before the last 16 carries 0. The last 16 slots carry the channel sample, most significant bit first, as seen at the rising bit-clock edges. tx_lrck_o high carries the left sample and low carries the right sample.
- R5: A pair is accepted in a cycle where tx_valid_i and tx_ready_o are both 1. tx_ready_o then stays 0 until the next frame start, which is the rising edge of tx_lrck_o. The accepted pair is sent in the frame that begins there. A frame that begins with no accepted pair waiting sends zeros in both halves.
- R6: A change of tx_fast_i takes effect only at the next frame start. The rest of the current frame keeps the old rate.
- R7: tx_mclk_o is the block clock, passed through unchanged.
- R8: With rx_fwd_i low, each channel sample is the last 16 bits sampled on rising rx_bclk_i edges before rx_lrck_i changes. This holds for 16 to 32 or more slots per half. Earlier slots are ignored.
- R9: With rx_fwd_i high, each channel sample is the first 16 bits sampled on rising rx_bclk_i edges from the edge on which rx_lrck_i changes. Later slots are ignored.
- R10: rx_lrck_i high marks left and low marks right. After a left half and then a right half have both completed, rx_valid_o pulses for exactly one cycle with the pair on rx_left_o and rx_right_o. The pulse follows the end of the right half. Both outputs hold their values between pulses.
- R11: After reset, the half in progress when the first rx_lrck_i change is seen is discarded. A right half that completes with no left half captured before it is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, 384x the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bclk_i | input | 1 | External receive bit clock |
| rx_lrck_i | input | 1 | External receive word clock (1 = left) |
| rx_data_i | input | 1 | Serial receive data |
| rx_fwd_i | input | 1 | Receive justification: 1 start of half, 0 end of half |
| rx_valid_o | output | 1 | One-cycle strobe for a new received pair |
| rx_left_o | output | 16 | Received left sample |
| rx_right_o | output | 16 | Received right sample |
| tx_fast_i | input | 1 | Transmit rate: 1 = 64 bits per frame, 0 = 48 |
| tx_valid_i | input | 1 | Core offers a pair to transmit |
| tx_ready_o | output | 1 | Block can accept a pair |
| tx_left_i | input | 16 | Left sample to transmit |
| tx_right_i | input | 16 | Right sample to transmit |
| tx_mclk_o | output | 1 | Master clock forwarded with the data |
| tx_bclk_o | output | 1 | Transmit bit clock |
| tx_lrck_o | output | 1 | Transmit word clock (1 = left) |
| tx_data_o | output | 1 | Serial transmit data |

## Verification
The receiver is swept over both justification modes at 16, 17, 24 and 32 slots per half. The unused slots hold a non-zero filler, so capturing too early or too late shows up as a wrong word rather than passing by accident. Each word is derived arithmetically from the frame index, and the ones that walk a single bit or alternate show whether the bits are in the right order. A partial half right after reset shows whether the receiver discards it. The transmitter is tried in four situations: pairs sent at both rates, frames with nothing pending (which must carry silence), and a rate change made in the middle of a frame, which shows whether the switch waits for the frame boundary.

// File: rtl/sap_pkg.sv
package sap_pkg;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_WAIT,
        RX_LEFT,
        RX_RIGHT
    } rx_state_t;

    typedef enum logic {
        TX_PAD,
        TX_DATA
    } tx_state_t;

endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d_i;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk_s,
    input  logic         lrck_s,
    input  logic         data_s,
    input  logic         fwd_i,
    output logic         valid_o,
    output logic [W-1:0] left_o,
    output logic [W-1:0] right_o
);

    localparam int CNTW = $clog2(W + 1);

    rx_state_t        state, state_nx;
    logic             bclk_d;
    logic             lr_prev;
    logic [W-1:0]     tail_sr;
    logic [W-1:0]     head_sr;
    logic [CNTW-1:0]  head_cnt;
    logic [W-1:0]     left_hold;
    logic             have_left;
    logic             rise;
    logic             lr_edge;
    logic [W-1:0]     word;

    assign rise    = bclk_s & ~bclk_d;
    assign lr_edge = rise && (state != RX_HUNT) && (lrck_s != lr_prev);
    assign word    = fwd_i ? head_sr : tail_sr;

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_HUNT:  if (rise)    state_nx = RX_WAIT;
            RX_WAIT:  if (lr_edge) state_nx = lrck_s ? RX_LEFT : RX_RIGHT;
            RX_LEFT:  if (lr_edge) state_nx = lrck_s ? RX_LEFT : RX_RIGHT;
            RX_RIGHT: if (lr_edge) state_nx = lrck_s ? RX_LEFT : RX_RIGHT;
        endcase
    end

    // state register and bit-level capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_HUNT;
            bclk_d   <= 1'b0;
            lr_prev  <= 1'b0;
            tail_sr  <= '0;
            head_sr  <= '0;
            head_cnt <= CNTW'(W);
        end else begin
            state  <= state_nx;
            bclk_d <= bclk_s;
            if (rise) begin
                lr_prev <= lrck_s;
                tail_sr <= {tail_sr[W-2:0], data_s};
                if (lr_edge) begin
                    head_sr  <= {head_sr[W-2:0], data_s};
                    head_cnt <= CNTW'(1);
                end else if (head_cnt < CNTW'(W)) begin
                    head_sr  <= {head_sr[W-2:0], data_s};
                    head_cnt <= head_cnt + 1'b1;
                end
            end
        end
    end

    // output process: half-frame latching and pair presentation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            left_hold <= '0;
            have_left <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (lr_edge) begin
                if (state == RX_LEFT) begin
                    left_hold <= word;
                    have_left <= 1'b1;
                end else if (state == RX_RIGHT && have_left) begin
                    left_o    <= left_hold;
                    right_o   <= word;
                    valid_o   <= 1'b1;
                    have_left <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int W          = 16,
    parameter int DIV_SLOW   = 8,
    parameter int DIV_FAST   = 6,
    parameter int SLOTS_SLOW = 24,
    parameter int SLOTS_FAST = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fast_i,
    input  logic         valid_i,
    input  logic [W-1:0] left_i,
    input  logic [W-1:0] right_i,
    output logic         ready_o,
    output logic         bclk_o,
    output logic         lrck_o,
    output logic         data_o
);

    localparam int DIV_MAX  = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int SLOT_MAX = (SLOTS_SLOW > SLOTS_FAST) ? SLOTS_SLOW : SLOTS_FAST;
    localparam int CW       = $clog2(DIV_MAX);
    localparam int SW       = $clog2(SLOT_MAX);
    localparam int IW       = $clog2(W);

    tx_state_t     state, state_nx;
    logic [CW-1:0] div_cnt, div_last, div_half;
    logic [SW-1:0] slot, slot_last, pad_last;
    logic          fast_q;
    logic          lrck_q;
    logic          tick, last_slot, frame_start;
    logic [W-1:0]  pend_l, pend_r, act_l, act_r;
    logic          pend_full;
    logic [IW-1:0] bit_sel;
    logic [W-1:0]  word;

    always_comb begin
        div_last  = fast_q ? CW'(DIV_FAST - 1)       : CW'(DIV_SLOW - 1);
        div_half  = fast_q ? CW'(DIV_FAST / 2)       : CW'(DIV_SLOW / 2);
        slot_last = fast_q ? SW'(SLOTS_FAST - 1)     : SW'(SLOTS_SLOW - 1);
        pad_last  = fast_q ? SW'(SLOTS_FAST - W - 1) : SW'(SLOTS_SLOW - W - 1);
    end

    assign tick        = (div_cnt == div_last);
    assign last_slot   = (slot == slot_last);
    assign frame_start = tick && last_slot && !lrck_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_PAD:  if (tick && slot == pad_last) state_nx = TX_DATA;
            TX_DATA: if (tick && last_slot)        state_nx = TX_PAD;
        endcase
    end

    // state register with divider, slot counter and word clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_PAD;
            div_cnt <= '0;
            slot    <= '0;
            lrck_q  <= 1'b1;
            fast_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (tick) begin
                div_cnt <= '0;
                slot    <= last_slot ? '0 : slot + 1'b1;
                if (last_slot) lrck_q <= ~lrck_q;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
            if (frame_start) fast_q <= fast_i;
        end
    end

    // pair handshake: one pending slot, promoted at each frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_l    <= '0;
            pend_r    <= '0;
            pend_full <= 1'b0;
            act_l     <= '0;
            act_r     <= '0;
        end else begin
            if (frame_start) begin
                act_l <= pend_full ? pend_l : '0;
                act_r <= pend_full ? pend_r : '0;
            end
            if (valid_i && !pend_full) begin
                pend_l    <= left_i;
                pend_r    <= right_i;
                pend_full <= 1'b1;
            end else if (frame_start) begin
                pend_full <= 1'b0;
            end
        end
    end

    // output process
    always_comb begin
        ready_o = ~pend_full;
        lrck_o  = lrck_q;
        bclk_o  = (div_cnt >= div_half);
        word    = lrck_q ? act_l : act_r;
        bit_sel = IW'(slot_last - slot);
        data_o  = (state == TX_DATA) && word[bit_sel];
    end

endmodule

// File: rtl/sap_port.sv
module sap_port #(
    parameter int SAMPLE_W    = 16,
    parameter int MCLK_RATIO  = 384,
    parameter int SLOW_RATIO  = 48,
    parameter int FAST_RATIO  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_bclk_i,
    input  logic                rx_lrck_i,
    input  logic                rx_data_i,
    input  logic                rx_fwd_i,
    output logic                rx_valid_o,
    output logic [SAMPLE_W-1:0] rx_left_o,
    output logic [SAMPLE_W-1:0] rx_right_o,
    input  logic                tx_fast_i,
    input  logic                tx_valid_i,
    output logic                tx_ready_o,
    input  logic [SAMPLE_W-1:0] tx_left_i,
    input  logic [SAMPLE_W-1:0] tx_right_i,
    output logic                tx_mclk_o,
    output logic                tx_bclk_o,
    output logic                tx_lrck_o,
    output logic                tx_data_o
);

    localparam int DIV_SLOW   = MCLK_RATIO / SLOW_RATIO;
    localparam int DIV_FAST   = MCLK_RATIO / FAST_RATIO;
    localparam int SLOTS_SLOW = SLOW_RATIO / 2;
    localparam int SLOTS_FAST = FAST_RATIO / 2;

    logic [2:0] rx_sync;

    sap_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({rx_bclk_i, rx_lrck_i, rx_data_i}),
        .q_o   (rx_sync)
    );

    sap_rx #(.W(SAMPLE_W)) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_s  (rx_sync[2]),
        .lrck_s  (rx_sync[1]),
        .data_s  (rx_sync[0]),
        .fwd_i   (rx_fwd_i),
        .valid_o (rx_valid_o),
        .left_o  (rx_left_o),
        .right_o (rx_right_o)
    );

    sap_tx #(
        .W          (SAMPLE_W),
        .DIV_SLOW   (DIV_SLOW),
        .DIV_FAST   (DIV_FAST),
        .SLOTS_SLOW (SLOTS_SLOW),
        .SLOTS_FAST (SLOTS_FAST)
    ) i_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast_i  (tx_fast_i),
        .valid_i (tx_valid_i),
        .left_i  (tx_left_i),
        .right_i (tx_right_i),
        .ready_o (tx_ready_o),
        .bclk_o  (tx_bclk_o),
        .lrck_o  (tx_lrck_o),
        .data_o  (tx_data_o)
    );

    assign tx_mclk_o = clk;

endmodule

// File: rtl/sap_port_chk.sv
module sap_port_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tx_bclk_o,
    input logic         tx_lrck_o,
    input logic         tx_data_o,
    input logic         tx_ready_o,
    input logic         tx_valid_i,
    input logic         rx_valid_o,
    input logic [W-1:0] rx_left_o,
    input logic [W-1:0] rx_right_o
);

    AST_TX_LRCK_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_lrck_o) |-> $fell(tx_bclk_o)); // R3

    AST_TX_DATA_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_data_o) |-> $fell(tx_bclk_o)); // R3

    AST_TX_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_ready_o) |=> !tx_ready_o); // R5

    AST_TX_READY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready_o) |-> $rose(tx_lrck_o)); // R5

    AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R10

    AST_RX_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rx_left_o) || !$stable(rx_right_o)) |-> rx_valid_o); // R10

endmodule

bind sap_port sap_port_chk #(.W(SAMPLE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_bclk_o  (tx_bclk_o),
    .tx_lrck_o  (tx_lrck_o),
    .tx_data_o  (tx_data_o),
    .tx_ready_o (tx_ready_o),
    .tx_valid_i (tx_valid_i),
    .rx_valid_o (rx_valid_o),
    .rx_left_o  (rx_left_o),
    .rx_right_o (rx_right_o)
);

// File: tb/test_sap_port.sv
module test_sap_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_bclk = 1'b0, rx_lrck = 1'b1, rx_data = 1'b0, rx_fwd = 1'b0;
    logic        rx_valid;
    logic [15:0] rx_left, rx_right;
    logic        tx_fast = 1'b0, tx_valid = 1'b0;
    logic        tx_ready;
    logic [15:0] tx_l = '0, tx_r = '0;
    logic        tx_mclk, tx_bclk, tx_lrck, tx_data;

    int checks = 0;
    int errors = 0;
    int rx_cnt = 0;
    logic [15:0] got_l = '0, got_r = '0;

    always #5 clk = ~clk;

    sap_port i_sap_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bclk_i  (rx_bclk),
        .rx_lrck_i  (rx_lrck),
        .rx_data_i  (rx_data),
        .rx_fwd_i   (rx_fwd),
        .rx_valid_o (rx_valid),
        .rx_left_o  (rx_left),
        .rx_right_o (rx_right),
        .tx_fast_i  (tx_fast),
        .tx_valid_i (tx_valid),
        .tx_ready_o (tx_ready),
        .tx_left_i  (tx_l),
        .tx_right_i (tx_r),
        .tx_mclk_o  (tx_mclk),
        .tx_bclk_o  (tx_bclk),
        .tx_lrck_o  (tx_lrck),
        .tx_data_o  (tx_data)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt <= rx_cnt + 1;
            got_l  <= rx_left;
            got_r  <= rx_right;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic filler(input int s);
        return (s % 3) != 1;
    endfunction

    task automatic rx_slot(input logic lr, input logic d);
        rx_bclk = 1'b0;
        rx_lrck = lr;
        rx_data = d;
        repeat (3) @(negedge clk);
        rx_bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rx_half(input logic lr, input logic [15:0] w, input int n, input logic fwd);
        for (int s = 0; s < n; s++) begin
            logic d;
            if (fwd) d = (s < 16) ? w[15-s] : filler(s);
            else     d = (s < n - 16) ? filler(s) : w[15-(s-(n-16))];
            rx_slot(lr, d);
        end
    endtask

    task automatic tx_send(input logic [15:0] l, input logic [15:0] r);
        while (!tx_ready) @(negedge clk);
        tx_l = l;
        tx_r = r;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check(tx_ready == 1'b0, "R5", "ready after accept", tx_ready, 0);
    endtask

    task automatic tx_wait_frame();
        while (!tx_ready) @(negedge clk);
        check(tx_lrck == 1'b1, "R5", "ready returns at frame start", tx_lrck, 1);
    endtask

    task automatic tx_half(input int d, input int slots, input logic lr,
                           input logic [15:0] w, input string req);
        logic [63:0] bits = '0;
        int   n = 0, per = 0, hi = 0;
        logic bad_clk = 1'b0, bad_edge = 1'b0;
        logic lr0 = tx_lrck;
        logic pb = tx_bclk, pd = tx_data;
        check(lr0 == lr, "R4", "half channel level", lr0, lr);
        forever begin
            @(negedge clk);
            if (tx_lrck != lr0) break;
            if (tx_data != pd && !(pb && !tx_bclk)) bad_edge = 1'b1;
            if (tx_bclk && !pb) begin
                if (n > 0 && (per != d || hi != d / 2)) bad_clk = 1'b1;
                per = 1;
                hi = 1;
                bits = {bits[62:0], tx_data};
                n++;
            end else begin
                per++;
                hi += int'(tx_bclk);
            end
            pb = tx_bclk;
            pd = tx_data;
        end
        check(n == slots, req, "slots per half", n, slots);
        check(!bad_clk, "R2", "bit clock period/duty", per, d);
        check(!bad_edge, "R3", "data change off falling edge", 1, 0);
        check((bits >> 16) == 0, "R4", "leading pad zero", bits >> 16, 0);
        check(bits[15:0] == w, "R4", "sample bits", bits[15:0], w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        logic [15:0] pl, pr;
        logic [15:0] a_l, a_r;
        repeat (3) @(negedge clk);
        check(tx_lrck == 1 && tx_bclk == 0 && tx_data == 0 && tx_ready == 1 && rx_valid == 0,
              "R1", "outputs in reset", {tx_lrck, tx_bclk, tx_data, tx_ready, rx_valid}, 5'b10010);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_lrck == 1 && tx_bclk == 0 && tx_data == 0 && tx_ready == 1 && rx_valid == 0,
              "R1", "outputs after reset", {tx_lrck, tx_bclk, tx_data, tx_ready, rx_valid}, 5'b10010);
        check(tx_mclk == 1'b0, "R7", "mclk low phase", tx_mclk, 0);
        @(posedge clk); #1;
        check(tx_mclk == 1'b1, "R7", "mclk high phase", tx_mclk, 1);
        @(negedge clk);

        // R11: partial left, right with no left, then full frames
        rx_fwd = 1'b0;
        rx_half(1'b1, 16'hFFFF, 5, 1'b0);
        rx_half(1'b0, 16'h1234, 16, 1'b0);
        a_l = 16'hC3A5;
        a_r = 16'h5A3C;
        rx_half(1'b1, a_l, 16, 1'b0);
        rx_half(1'b0, a_r, 16, 1'b0);
        check(rx_cnt == 0, "R11", "no pair from partial halves", rx_cnt, 0);
        rx_half(1'b1, 16'h0F0F, 16, 1'b0);
        rx_half(1'b0, 16'hF0F0, 16, 1'b0);
        check(rx_cnt == 1, "R11", "first full pair reported", rx_cnt, 1);
        check(got_l == a_l && got_r == a_r, "R11", "first pair value", {got_l, got_r}, {a_l, a_r});

        // R8/R9/R10 sweep over modes and slot counts
        for (int m = 0; m < 2; m++) begin
            for (int ni = 0; ni < 4; ni++) begin
                int n;
                n = (ni == 0) ? 16 : (ni == 1) ? 17 : (ni == 2) ? 24 : 32;
                rx_fwd = logic'(m);
                pl = '0;
                pr = '0;
                for (int k = 0; k < 4; k++) begin
                    logic [15:0] wl, wr;
                    wl = (k == 0) ? 16'h8000 >> (ni + 4 * m) : 16'(k * 16'h1357 + n * 16'h0101) ^ 16'hA5A5;
                    wr = (k == 1) ? 16'h0001 << (ni + 4 * m) : ~wl ^ 16'(k * 16'h0F11);
                    base = rx_cnt;
                    rx_half(1'b1, wl, n, logic'(m));
                    rx_half(1'b0, wr, n, logic'(m));
                    if (k > 0) begin
                        check(rx_cnt - base == 1, "R10", "one strobe per frame", rx_cnt - base, 1);
                        if (m == 0)
                            check(got_l == pl && got_r == pr, "R8", "end-justified pair",
                                  {got_l, got_r}, {pl, pr});
                        else
                            check(got_l == pl && got_r == pr, "R9", "start-justified pair",
                                  {got_l, got_r}, {pl, pr});
                    end
                    pl = wl;
                    pr = wr;
                end
            end
        end

        // Transmitter
        tx_send(16'h8001, 16'h7FFE);
        tx_wait_frame();
        tx_half(8, 24, 1'b1, 16'h8001, "R2");
        tx_half(8, 24, 1'b0, 16'h7FFE, "R2");
        tx_half(8, 24, 1'b1, 16'h0000, "R5");
        tx_half(8, 24, 1'b0, 16'h0000, "R5");
        tx_send(16'hA5A5, 16'h3C3C);
        tx_wait_frame();
        tx_half(8, 24, 1'b1, 16'hA5A5, "R4");
        tx_fast = 1'b1;
        tx_half(8, 24, 1'b0, 16'h3C3C, "R6");
        tx_half(6, 32, 1'b1, 16'h0000, "R6");
        tx_half(6, 32, 1'b0, 16'h0000, "R6");
        for (int k = 0; k < 4; k++) begin
            logic [15:0] wl, wr;
            wl = 16'h8000 >> (k * 5);
            wr = 16'(k * 16'h2469) ^ 16'hFFFF;
            tx_send(wl, wr);
            tx_wait_frame();
            tx_half(6, 32, 1'b1, wl, "R2");
            tx_half(6, 32, 1'b0, wr, "R2");
        end
        tx_half(6, 32, 1'b1, 16'h0000, "R5");
        tx_fast = 1'b0;
        tx_half(6, 32, 1'b0, 16'h0000, "R6");
        tx_send(16'h1357, 16'hFDB9);
        tx_wait_frame();
        tx_half(8, 24, 1'b1, 16'h1357, "R6");
        tx_half(8, 24, 1'b0, 16'hFDB9, "R4");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule